// File: doc/BRIEF.md
# Register-Addressed Single-Byte I2C Master

This block is an I2C bus master that moves exactly one byte per command to or from a numbered register inside a slave device. Every command opens with a START and the 7-bit slave address with the write direction. A sub-register address byte always follows, and this phase cannot be skipped. A write then sends one data byte and closes with STOP. A read turns the bus round with a repeated START and the address with the read direction. It then takes in one byte, answers it with NACK and closes with STOP.

There is no FIFO. Software sets up the slave address, the sub-register byte and the data byte, then pulses a start command. It polls sticky status bits for completion, acknowledge failure or bus timeout, and each of those bits is cleared by writing one. When no sub-register address has been programmed, the block sends a fallback byte taken from a field of the control register. The SCL low and high periods are separate inputs counted in core-clock cycles. Both bus lines are open-drain: the block either pulls a line low or releases it.

Top module: `i2cm_top`

## Requirements
- R1: After reset `busy_o` is 0, `status_o` is 3'b000, `rdata_o` is 8'h00, and `scl_oe_o` and `sda_oe_o` are 0. Both line enables stay 0 whenever `busy_o` is 0.
- R2: A `start_i` pulse is taken only when `busy_o` is 0 and `addr_valid_i` is 1, and `busy_o` rises one cycle later. A pulse while busy has no effect on the bus or on the bytes sent. A pulse with `addr_valid_i` at 0 leaves the block idle.
- R3: A write (`rd_i`=0) sends START, {address,0}, the sub-register byte, the data byte and STOP, each byte MSB first with the slave acknowledge sampled in the ninth clock. It then sets `status_o[0]` (done).
- R4: A read (`rd_i`=1) sends START, {address,0}, the sub-register byte, a repeated START and {address,1}. It then receives 8 bits MSB first and releases SDA in the ninth clock (NACK). After that it sends STOP, sets `status_o[0]`, and holds the received byte on `rdata_o` until the next read.
- R5: When `sub_valid_i` is 1 the sub-register byte is `sub_addr_i`. Otherwise it is `ctrl_sub_i`, the bits [18:11] of the control register.
- R6: A high SDA in any acknowledge slot sent by the slave sets `status_o[1]` (ACK error) while the block is still busy. No further byte is sent. A STOP follows, then `status_o[0]` is set.
- R7: If SCL stays low for `tmo_limit_i` consecutive cycles after the block released it, `status_o[2]` is set, both lines are released and the block goes idle without setting done. A shorter stretch only delays the transfer.
- R8: Each bit drives SCL low for exactly `scl_low_i` cycles. A data bit with no stretching keeps SCL released for `scl_high_i`+1 cycles: one cycle to see the rising edge, on which SDA is sampled, then `scl_high_i` cycles.
- R9: Status bits are sticky. A 1 in `clr_i[n]` clears `status_o[n]` on the next edge. A bit set on the same edge as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle command pulse |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_valid_i | input | 1 | Slave address has been programmed |
| slave_addr_i | input | 7 | 7-bit slave address |
| sub_valid_i | input | 1 | Sub-register address has been programmed |
| sub_addr_i | input | 8 | Programmed sub-register address |
| ctrl_sub_i | input | 8 | Control-register field [18:11], fallback sub-register address |
| wdata_i | input | 8 | Byte to write |
| scl_low_i | input | TW | SCL low period in cycles |
| scl_high_i | input | TW | SCL high period in cycles |
| tmo_limit_i | input | TW | Stretch cycles that trip the timeout |
| clr_i | input | 3 | Write-one-to-clear for status bits |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Transfer in progress |
| status_o | output | 3 | {timeout, ACK error, done} |
| rdata_o | output | 8 | Last byte read |

## Verification
A wrong phase or bit counter shows at the ports within one byte time. The slave model on the bench decodes a different address, register or data value, or sees a STOP or repeated START in the wrong place, and by the end of the command the stored byte or `rdata_o` no longer matches. A broken SCL period counter shows as a wrong low or high run length on the very next bit. A faulty stretch guard changes the exact number of busy cycles before the timeout. A status register that forgets its bits or clears the wrong one is visible on the next edge after a clear pulse.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int STAT_W      = 3;
    localparam int STAT_DONE   = 0;
    localparam int STAT_ACKERR = 1;
    localparam int STAT_TMO    = 2;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_START,
        BUS_LOW,
        BUS_WAIT,
        BUS_HIGH,
        BUS_STOP
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_ADDR_W,
        PH_SUB,
        PH_WDATA,
        PH_RESTART,
        PH_ADDR_R,
        PH_RDATA,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic [7:0] sub;
        logic [7:0] wdata;
    } xfer_t;

    function automatic logic [7:0] pick_sub(input logic valid, input logic [7:0] prog,
                                            input logic [7:0] fallback);
        return valid ? prog : fallback;
    endfunction

    function automatic logic [7:0] frame_byte(input phase_e ph, input xfer_t x);
        case (ph)
            PH_ADDR_W: return {x.addr, 1'b0};
            PH_ADDR_R: return {x.addr, 1'b1};
            PH_SUB:    return x.sub;
            PH_WDATA:  return x.wdata;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic phase_e next_tx(input phase_e ph, input logic rd);
        case (ph)
            PH_ADDR_W: return PH_SUB;
            PH_SUB:    return rd ? PH_RESTART : PH_WDATA;
            PH_ADDR_R: return PH_RDATA;
            default:   return PH_STOP;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] len,
    output logic          expire
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;

    assign nxt    = {1'b0, cnt} + (CW+1)'(1);
    assign expire = run && (nxt >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_stretch_guard.sv
module i2cm_stretch_guard #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          watch,
    input  logic          held,
    input  logic [CW-1:0] limit,
    output logic          trip
);
    logic [CW-1:0] cnt;

    assign trip = watch && held && (({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !watch)     cnt <= '0;
        else if (held && !trip) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic              addr_valid_i,
    input  logic [6:0]        slave_addr_i,
    input  logic              sub_valid_i,
    input  logic [7:0]        sub_addr_i,
    input  logic [7:0]        ctrl_sub_i,
    input  logic [7:0]        wdata_i,
    input  logic [TW-1:0]     scl_low_i,
    input  logic [TW-1:0]     scl_high_i,
    input  logic [TW-1:0]     tmo_limit_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic [STAT_W-1:0] status_o,
    output logic [7:0]        rdata_o
);
    bus_st_e     state;
    phase_e      phase;
    xfer_t       xfer;
    logic [3:0]  bitn;
    logic        smp;
    logic [6:0]  rx_sh;

    logic          run, expire, trip, bit_out, tx_phase;
    logic [TW-1:0] len;
    logic [7:0]    cur_byte;
    logic [STAT_W-1:0] set_vec;

    assign run = (state == BUS_START) || (state == BUS_LOW) ||
                 (state == BUS_HIGH)  || (state == BUS_STOP);
    assign len = (state == BUS_LOW) ? scl_low_i : scl_high_i;

    i2cm_phase_timer #(.CW(TW)) timer_i (
        .clk(clk), .rst(rst), .run(run), .len(len), .expire(expire)
    );

    i2cm_stretch_guard #(.CW(TW)) guard_i (
        .clk(clk), .rst(rst), .watch(state == BUS_WAIT), .held(!scl_i),
        .limit(tmo_limit_i), .trip(trip)
    );

    assign tx_phase = (phase == PH_ADDR_W) || (phase == PH_SUB) ||
                      (phase == PH_WDATA)  || (phase == PH_ADDR_R);
    assign cur_byte = frame_byte(phase, xfer);

    always_comb begin
        if (tx_phase)               bit_out = bitn[3] ? 1'b1 : cur_byte[3'd7 - bitn[2:0]];
        else if (phase == PH_STOP)  bit_out = 1'b0;
        else                        bit_out = 1'b1;
    end

    assign scl_oe_o = (state == BUS_LOW);
    assign sda_oe_o = (state == BUS_START) ||
                      (((state == BUS_LOW) || (state == BUS_WAIT) || (state == BUS_HIGH)) && !bit_out);
    assign busy_o   = (state != BUS_IDLE);

    always_comb begin
        set_vec              = '0;
        set_vec[STAT_DONE]   = (state == BUS_STOP) && expire;
        set_vec[STAT_TMO]    = (state == BUS_WAIT) && !scl_i && trip;
        set_vec[STAT_ACKERR] = (state == BUS_HIGH) && expire && tx_phase && bitn[3] && smp;
    end

    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= (status_o & ~clr_i) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= BUS_IDLE;
            phase   <= PH_ADDR_W;
            xfer    <= '0;
            bitn    <= '0;
            smp     <= 1'b1;
            rx_sh   <= '0;
            rdata_o <= '0;
        end else begin
            case (state)
                BUS_IDLE: if (start_i && addr_valid_i) begin
                    xfer  <= '{addr: slave_addr_i, rd: rd_i,
                               sub: pick_sub(sub_valid_i, sub_addr_i, ctrl_sub_i),
                               wdata: wdata_i};
                    phase <= PH_ADDR_W;
                    bitn  <= '0;
                    state <= BUS_START;
                end
                BUS_START: if (expire) state <= BUS_LOW;
                BUS_LOW:   if (expire) state <= BUS_WAIT;
                BUS_WAIT: begin
                    if (scl_i) begin
                        smp   <= sda_i;
                        state <= BUS_HIGH;
                    end else if (trip) begin
                        state <= BUS_IDLE;
                    end
                end
                BUS_HIGH: if (expire) begin
                    state <= BUS_LOW;
                    bitn  <= bitn + 1'b1;
                    case (phase)
                        PH_RESTART: begin
                            state <= BUS_START;
                            phase <= PH_ADDR_R;
                            bitn  <= '0;
                        end
                        PH_STOP: state <= BUS_STOP;
                        PH_RDATA: begin
                            rx_sh <= {rx_sh[5:0], smp};
                            if (bitn == 4'd7) rdata_o <= {rx_sh, smp};
                            if (bitn[3]) begin
                                phase <= PH_STOP;
                                bitn  <= '0;
                            end
                        end
                        default: if (bitn[3]) begin
                            bitn  <= '0;
                            phase <= smp ? PH_STOP : next_tx(phase, xfer.rd);
                        end
                    endcase
                end
                BUS_STOP: if (expire) state <= BUS_IDLE;
                default:  state <= BUS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_top_chk.sv
module i2cm_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       addr_valid_i,
    input logic       busy_o,
    input logic [2:0] status_o,
    input logic [2:0] clr_i,
    input logic       scl_oe_o,
    input logic       sda_oe_o
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    // R2
    no_addr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !addr_valid_i) |=> !busy_o);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && addr_valid_i) |=> busy_o);

    // R6
    ackerr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[1]) |-> busy_o);

    // R7
    tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[2]) |-> (!busy_o && !scl_oe_o && !sda_oe_o && !status_o[0]));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_o & ($past(status_o) & ~$past(clr_i))) == ($past(status_o) & ~$past(clr_i))));

    // R3
    end_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (status_o[0] || status_o[2]));
endmodule

bind i2cm_top i2cm_top_chk chk_i (.*);

// File: tb/i2cm_top_tb.sv
module i2cm_top_tb_top;
    localparam int TW    = 16;
    localparam int SCL_L = 4;
    localparam int SCL_H = 3;
    localparam int TMO   = 40;
    localparam logic [6:0] SLV = 7'h2C;

    typedef struct packed {
        logic       rd;
        logic       use_sub;
        logic [7:0] sub;
        logic [7:0] wd;
        logic [7:0] fb;
        logic       ack;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'h10, 8'hA5, 8'h00, 1'b1},
        '{1'b1, 1'b1, 8'h10, 8'h00, 8'h00, 1'b1},
        '{1'b0, 1'b0, 8'h77, 8'h3C, 8'h33, 1'b1},
        '{1'b1, 1'b0, 8'h77, 8'h00, 8'h33, 1'b1},
        '{1'b1, 1'b1, 8'h80, 8'h00, 8'h44, 1'b1},
        '{1'b0, 1'b1, 8'h20, 8'h11, 8'h00, 1'b0},
        '{1'b1, 1'b1, 8'h21, 8'h00, 8'h00, 1'b0},
        '{1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1}
    };

    logic clk = 0;
    logic rst = 1;
    logic start_i = 0, rd_i = 0, addr_valid_i = 0, sub_valid_i = 0;
    logic [6:0] slave_addr_i = SLV;
    logic [7:0] sub_addr_i = 0, ctrl_sub_i = 0, wdata_i = 0;
    logic [TW-1:0] scl_low_i = SCL_L, scl_high_i = SCL_H, tmo_limit_i = TMO;
    logic [2:0] clr_i = 0;
    logic scl_oe_o, sda_oe_o, busy_o;
    logic [2:0] status_o;
    logic [7:0] rdata_o;

    logic s_hold = 0, s_drv = 0;
    logic scl_line, sda_line;
    assign scl_line = !(scl_oe_o || s_hold);
    assign sda_line = !(sda_oe_o || s_drv);

    always #5 clk = ~clk;

    i2cm_top #(.TW(TW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .addr_valid_i(addr_valid_i),
        .slave_addr_i(slave_addr_i), .sub_valid_i(sub_valid_i), .sub_addr_i(sub_addr_i),
        .ctrl_sub_i(ctrl_sub_i), .wdata_i(wdata_i), .scl_low_i(scl_low_i),
        .scl_high_i(scl_high_i), .tmo_limit_i(tmo_limit_i), .clr_i(clr_i),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .busy_o(busy_o), .status_o(status_o), .rdata_o(rdata_o)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slave model
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic ack_en = 1, p_scl = 1, p_sda = 1, a_ok = 0, rd_m = 0, tx_on = 0, m_nack = 0;
    logic [7:0] sh = 0, sreg = 0;
    int bc = 0, nbyte = 0, n_start = 0, n_stop = 0, n_wr = 0;

    always @(negedge clk) begin
        if (rst) begin
            bc = 0; nbyte = 0; tx_on = 0; s_drv = 0; p_scl = 1; p_sda = 1;
        end else begin
            if (p_scl && scl_line && p_sda && !sda_line) begin
                bc = 0; nbyte = 0; tx_on = 0; s_drv = 0; n_start++;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                n_stop++; s_drv = 0; tx_on = 0;
            end else if (!p_scl && scl_line) begin
                if (bc < 8) sh = {sh[6:0], sda_line};
                else if (tx_on) m_nack = sda_line;
                bc++;
            end else if (p_scl && !scl_line) begin
                if (bc == 8) begin
                    s_drv = 0;
                    if (!tx_on) begin
                        if (nbyte == 0) begin
                            a_ok = ack_en && (sh[7:1] == SLV);
                            rd_m = sh[0];
                            s_drv = a_ok;
                        end else if (a_ok) begin
                            if (nbyte == 1) sreg = sh;
                            else begin mem[sreg] = sh; n_wr++; end
                            s_drv = 1;
                        end
                        nbyte++;
                    end
                end else if (bc == 9) begin
                    bc = 0; s_drv = 0;
                    if (tx_on) tx_on = 0;
                    else if (rd_m && a_ok && nbyte == 1) begin
                        tx_on = 1; s_drv = !mem[sreg][7];
                    end
                end else if (tx_on && bc >= 1 && bc <= 7) begin
                    s_drv = !mem[sreg][7-bc];
                end
            end
            p_scl = scl_line; p_sda = sda_line;
        end
    end

    // SCL run-length monitor
    int run_lo = 0, run_hi = 0, min_lo = 0, max_lo = 0, min_hi = 0;
    logic seen_lo = 0;
    always @(negedge clk) begin
        if (scl_oe_o) begin
            if (run_hi > 0 && seen_lo && (min_hi == 0 || run_hi < min_hi)) min_hi = run_hi;
            run_hi = 0; run_lo++;
        end else begin
            if (run_lo > 0) begin
                if (min_lo == 0 || run_lo < min_lo) min_lo = run_lo;
                if (run_lo > max_lo) max_lo = run_lo;
                seen_lo = 1;
            end
            run_lo = 0;
            if (busy_o) run_hi++;
        end
    end

    int busy_cycles = 0;
    always @(negedge clk) if (busy_o) busy_cycles++;

    task automatic wait_idle();
        int k = 0;
        while (busy_o && k < 5000) begin @(negedge clk); k++; end
        if (busy_o) chk(0, "watchdog", 32'd1, 32'd0);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask

    task automatic clear_all();
        clr_i = 3'b111; @(negedge clk); clr_i = 0;
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && status_o == 0 && rdata_o == 0 && !scl_oe_o && !sda_oe_o,
            "R1 reset", {busy_o, status_o, rdata_o, scl_oe_o, sda_oe_o}, 32'd0);

        // R2 no slave address programmed
        addr_valid_i = 0;
        pulse_start();
        chk(!busy_o, "R2 no-addr busy", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(n_start == 0 && !scl_oe_o && !sda_oe_o, "R2 no-addr bus", n_start, 0);
        addr_valid_i = 1;

        // table walk: R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            automatic vec_t t = VECS[v];
            automatic logic [7:0] es = t.use_sub ? t.sub : t.fb;
            automatic int st0 = n_stop, wr0 = n_wr;
            automatic logic [7:0] rd0 = rdata_o;
            rd_i = t.rd; sub_valid_i = t.use_sub; sub_addr_i = t.sub;
            ctrl_sub_i = t.fb; wdata_i = t.wd; ack_en = t.ack; m_nack = 0;
            min_lo = 0; max_lo = 0; min_hi = 0; seen_lo = 0;
            pulse_start();
            chk(busy_o, "R2 busy rise", busy_o, 1);
            wait_idle();
            chk(status_o == (t.ack ? 3'b001 : 3'b011), t.ack ? "R3/R4 status" : "R6 status",
                status_o, t.ack ? 3'b001 : 3'b011);
            chk(n_stop == st0 + 1, "R6 stop issued", n_stop - st0, 1);
            if (t.ack && !t.rd) begin
                exp_mem[es] = t.wd;
                chk(mem[es] == t.wd && n_wr == wr0 + 1, t.use_sub ? "R3 write" : "R5 write fallback",
                    mem[es], t.wd);
            end else if (t.ack && t.rd) begin
                chk(rdata_o == exp_mem[es], t.use_sub ? "R4 read" : "R5 read fallback",
                    rdata_o, exp_mem[es]);
                chk(m_nack == 1, "R4 master nack", m_nack, 1);
            end else begin
                chk(n_wr == wr0 && rdata_o == rd0, "R6 nothing moved", n_wr - wr0, 0);
            end
            chk(min_lo == SCL_L && max_lo == SCL_L, "R8 low period", {min_lo[15:0], max_lo[15:0]}, SCL_L);
            chk(min_hi == SCL_H + 1, "R8 high period", min_hi, SCL_H + 1);
            if (v == 5) begin
                // R9 write-one-to-clear per bit
                clr_i = 3'b001; @(negedge clk); clr_i = 0;
                chk(status_o == 3'b010, "R9 clear done only", status_o, 3'b010);
                @(negedge clk);
                chk(status_o == 3'b010, "R9 sticky", status_o, 3'b010);
                clr_i = 3'b010; @(negedge clk); clr_i = 0;
                chk(status_o == 3'b000, "R9 clear ackerr", status_o, 0);
            end else begin
                clear_all();
            end
        end
        ack_en = 1;

        // R2 start while busy is ignored
        begin
            automatic int st0 = n_stop;
            rd_i = 0; sub_valid_i = 1; sub_addr_i = 8'h40; wdata_i = 8'h66;
            pulse_start();
            repeat (2) @(negedge clk);
            rd_i = 1; sub_addr_i = 8'h41; wdata_i = 8'h99;
            pulse_start();
            wait_idle();
            chk(mem[8'h40] == 8'h66, "R2 first kept", mem[8'h40], 8'h66);
            chk(mem[8'h41] == exp_mem[8'h41] && n_stop == st0 + 1, "R2 busy start ignored",
                n_stop - st0, 1);
            clear_all();
        end

        // R7 short stretch only delays
        rd_i = 0; sub_addr_i = 8'h50; wdata_i = 8'hC3;
        pulse_start();
        while (!scl_oe_o) @(negedge clk);
        s_hold = 1;
        while (scl_oe_o) @(negedge clk);
        repeat (TMO - 5) @(negedge clk);
        s_hold = 0;
        wait_idle();
        chk(status_o == 3'b001 && mem[8'h50] == 8'hC3, "R7 short stretch", status_o, 3'b001);
        clear_all();

        // R7 timeout
        sub_addr_i = 8'h51; wdata_i = 8'h0F;
        busy_cycles = 0;
        pulse_start();
        while (!scl_oe_o) @(negedge clk);
        s_hold = 1;
        wait_idle();
        chk(status_o == 3'b100, "R7 timeout status", status_o, 3'b100);
        chk(!scl_oe_o && !sda_oe_o, "R7 lines released", {scl_oe_o, sda_oe_o}, 0);
        chk(busy_cycles == SCL_H + SCL_L + TMO, "R7 timeout cycle", busy_cycles, SCL_H + SCL_L + TMO);
        s_hold = 0;
        repeat (3) @(negedge clk);
        clear_all();
        chk(status_o == 0, "R9 clear tmo", status_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule